// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic core of an 8-bit accumulator machine. It holds the machine's flag register: carry, zero, sign and parity. Each cycle the decoder presents an opcode, the current accumulator byte and a second operand byte that was already fetched, and raises `op_valid`. The block then computes the new accumulator value combinationally. `acc_wr` tells the surrounding datapath whether that value is to be latched into the accumulator.

On the same clock edge the block updates its own flag register. The operation set covers:

- the bitwise AND, OR and XOR groups;
- add and subtract, each with and without the incoming carry;
- four rotates, two of them through carry;
- increment, decrement and complement of the accumulator;
- BCD decimal adjust;
- standalone carry set, clear and invert;
- whole-byte transfers between the accumulator and the flag register.

The flag byte is laid out as: carry in bit 7, zero in bit 6, sign in bit 5, parity in bit 4. Bits 3..0 always read as zero. The parity flag is 1 when the result holds an odd number of one bits.

Top module: `acc_alu`

## Requirements
- R1: After reset `flags` reads 0x00, and bits 3..0 of `flags` read zero at all times.
- R2: Opcodes 0x80-0x87 give A AND operand, 0x88-0x8F give A OR operand, and 0x90-0x97 give A XOR operand. Each asserts `acc_wr` and leaves carry (bit 7) unchanged.
- R3: Opcodes 0xA0-0xA7 give A + operand, and opcodes 0xA8-0xAF give A + operand + carry, both modulo 256. Carry becomes the carry out of bit 7. The 0xA0 group ignores the incoming carry.
- R4: Opcodes 0xB0-0xB7 give A - operand, and opcodes 0xB8-0xBF give A - operand - carry, both modulo 256. Carry becomes 1 exactly when a borrow occurs.
- R5: Opcodes 0x98 (rotate left) and 0x9A (rotate right) rotate A by one bit within the byte and leave carry unchanged. Opcodes 0x99 and 0x9B rotate left and right through the carry as a 9-bit ring.
- R6: Opcode 0x9E increments A and opcode 0x9F decrements A, both wrapping modulo 256. Opcode 0x0F inverts every bit of A. None of the three changes carry.
- R7: Every result written to A updates the flags from that result, except the flags-to-A transfer: zero (bit 6) is set when the result is 0x00, sign (bit 5) equals result bit 7, and parity (bit 4) is 1 when the result has an odd number of one bits.
- R8: Opcode 0x08 sets carry, 0x09 clears carry and 0x0E inverts carry. These three keep `acc_wr` low and leave bits 6..4 unchanged.
- R9: Opcode 0x11 drives `acc_out` with the flag byte and asserts `acc_wr`, leaving the flags unchanged. Opcode 0x12 loads the flags from A bits 7..4, with bits 3..0 forced to zero, and keeps `acc_wr` low.
- R10: Opcode 0xFA (decimal adjust) works in two steps. First it adds 0x06 when the low nibble of A exceeds 9. Then it adds 0x60 when the high nibble of that sum exceeds 9, when that sum overflowed 8 bits, or when carry is set. Carry becomes 1 exactly when the 0x60 step is applied.
- R11: Any other opcode keeps `acc_wr` low and leaves the flags unchanged. With `op_valid` low, `acc_wr` is low and the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 8 | Decoded operation code |
| acc_in | input | 8 | Current accumulator value |
| operand | input | 8 | Second operand byte, already fetched |
| acc_out | output | 8 | New accumulator value (combinational) |
| acc_wr | output | 1 | Accumulator should latch `acc_out` |
| flags | output | 8 | Flag register: carry, zero, sign, parity in bits 7..4 |

## Verification
Each arithmetic group is driven with operand pairs chosen to separate the carry-in and carry-out paths:

- 0xFF+0x01 wraps to zero;
- 0x00-0x01 borrows;
- the carry-using variants are run once with carry set and once with it clear, so that an add that wrongly consumes carry is exposed.

The logic, rotate and increment groups use bytes with odd and even bit counts and with bit 7 both set and clear. This distinguishes the parity and sign flags, and checks that carry is left intact. Decimal adjust is tried with:

- a valid BCD sum;
- a low-nibble-only correction;
- a double correction;
- a case where an incoming carry forces the 0x60 step.

The flag transfers, a reserved opcode and an idle cycle confirm which paths leave the flag byte untouched.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    op_code,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] acc_out,
  output logic          acc_wr,
  output logic [7:0]    flags
);
  localparam int CB = 7, ZB = 6, SB = 5, PB = 4;

  logic [7:0]  fq, nf;
  logic [DW:0] r;
  logic        wr, cy_upd, zsp_upd, fl_load;
  wire         cy = fq[CB];

  wire          lo_fix = acc_in[3:0] > 4'd9;
  wire [DW:0]   da1    = {1'b0, acc_in} + (lo_fix ? (DW+1)'(6) : '0);
  wire          hi_fix = (da1[7:4] > 4'd9) || da1[DW] || cy;
  wire [DW-1:0] da2    = da1[DW-1:0] + (hi_fix ? DW'(8'h60) : '0);

  always_comb begin
    r       = {cy, acc_in};
    wr      = 1'b1;
    cy_upd  = 1'b0;
    zsp_upd = 1'b1;
    fl_load = 1'b0;
    case (op_code) inside
      [8'h80:8'h87]: r = {cy, acc_in & operand};
      [8'h88:8'h8F]: r = {cy, acc_in | operand};
      [8'h90:8'h97]: r = {cy, acc_in ^ operand};
      [8'hA0:8'hA7]: begin r = {1'b0, acc_in} + {1'b0, operand}; cy_upd = 1'b1; end
      [8'hA8:8'hAF]: begin r = {1'b0, acc_in} + {1'b0, operand} + (DW+1)'(cy); cy_upd = 1'b1; end
      [8'hB0:8'hB7]: begin r = {1'b0, acc_in} - {1'b0, operand}; cy_upd = 1'b1; end
      [8'hB8:8'hBF]: begin r = {1'b0, acc_in} - {1'b0, operand} - (DW+1)'(cy); cy_upd = 1'b1; end
      8'h98: r = {cy, acc_in[DW-2:0], acc_in[DW-1]};
      8'h99: begin r = {acc_in, cy}; cy_upd = 1'b1; end
      8'h9A: r = {cy, acc_in[0], acc_in[DW-1:1]};
      8'h9B: begin r = {acc_in[0], cy, acc_in[DW-1:1]}; cy_upd = 1'b1; end
      8'h9E: r = {cy, acc_in + DW'(1)};
      8'h9F: r = {cy, acc_in - DW'(1)};
      8'h0F: r = {cy, ~acc_in};
      8'hFA: begin r = {hi_fix, da2}; cy_upd = 1'b1; end
      8'h11: begin r = {cy, DW'(fq)}; zsp_upd = 1'b0; end
      8'h12: begin wr = 1'b0; zsp_upd = 1'b0; fl_load = 1'b1; end
      8'h08: begin wr = 1'b0; zsp_upd = 1'b0; r[DW] = 1'b1; cy_upd = 1'b1; end
      8'h09: begin wr = 1'b0; zsp_upd = 1'b0; r[DW] = 1'b0; cy_upd = 1'b1; end
      8'h0E: begin wr = 1'b0; zsp_upd = 1'b0; r[DW] = ~cy; cy_upd = 1'b1; end
      default: begin wr = 1'b0; zsp_upd = 1'b0; end
    endcase
  end

  always_comb begin
    nf = fq;
    if (cy_upd) nf[CB] = r[DW];
    if (zsp_upd) begin
      nf[ZB] = (r[DW-1:0] == '0);
      nf[SB] = r[DW-1];
      nf[PB] = ^r[DW-1:0];
    end
    if (fl_load) nf = {acc_in[DW-1:DW-4], 4'b0000};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        fq <= 8'h00;
    else if (op_valid) fq <= nf;

  assign acc_out = r[DW-1:0];
  assign acc_wr  = op_valid & wr;
  assign flags   = fq;

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && op_code != 8'h11) |=> (flags[ZB] == ($past(acc_out) == '0)));
  // R7
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && op_code != 8'h11) |=> (flags[SB] == $past(acc_out[DW-1])));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags));
  // R2
  logic_keeps_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code inside {[8'h80:8'h97]}) |=> (flags[CB] == $past(flags[CB])));
  // R8
  set_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 8'h08) |=> flags[CB]);
  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flags[3:0] == 4'h0));
endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [7:0] op_code = '0, acc_in = '0, operand = '0;
  logic [7:0] acc_out, flags;
  logic       acc_wr;
  int nchk = 0, nerr = 0;
  logic [7:0] mf = 8'h00;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_alu u_acc_alu (.clk, .rst_n, .op_valid, .op_code, .acc_in, .operand,
                     .acc_out, .acc_wr, .flags);

  function automatic int ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  // returns {wr, result, new_flags}
  function automatic logic [16:0] mdl(input logic [7:0] op, a, b, f);
    int c = f[7], s;
    int newc = c;
    bit w = 1, zsp = 1;
    logic [7:0] res = a;
    logic [7:0] nf = f;
    if (op >= 8'h80 && op <= 8'h87) res = a & b;
    else if (op >= 8'h88 && op <= 8'h8F) res = a | b;
    else if (op >= 8'h90 && op <= 8'h97) res = a ^ b;
    else if (op >= 8'hA0 && op <= 8'hAF) begin
      s = int'(a) + int'(b) + ((op >= 8'hA8) ? c : 0);
      res = 8'(s); newc = (s > 255);
    end else if (op >= 8'hB0 && op <= 8'hBF) begin
      s = int'(a) - int'(b) - ((op >= 8'hB8) ? c : 0);
      res = 8'(s); newc = (s < 0);
    end else if (op == 8'h98) res = 8'((int'(a) * 2) % 256 + int'(a) / 128);
    else if (op == 8'h99) begin res = 8'((int'(a) * 2) % 256 + c); newc = a[7]; end
    else if (op == 8'h9A) res = 8'(int'(a) / 2 + (int'(a) % 2) * 128);
    else if (op == 8'h9B) begin res = 8'(int'(a) / 2 + c * 128); newc = a[0]; end
    else if (op == 8'h9E) res = 8'((int'(a) + 1) % 256);
    else if (op == 8'h9F) res = 8'((int'(a) + 255) % 256);
    else if (op == 8'h0F) res = 8'(255 - int'(a));
    else if (op == 8'hFA) begin
      s = int'(a);
      if (s % 16 > 9) s += 6;
      if (((s % 256) / 16) > 9 || s > 255 || c == 1) begin s = (s % 256) + 96; newc = 1; end
      else newc = 0;
      res = 8'(s);
    end else if (op == 8'h11) begin res = f; zsp = 0; end
    else if (op == 8'h12) begin w = 0; zsp = 0; nf = {a[7:4], 4'h0}; end
    else if (op == 8'h08) begin w = 0; zsp = 0; newc = 1; end
    else if (op == 8'h09) begin w = 0; zsp = 0; newc = 0; end
    else if (op == 8'h0E) begin w = 0; zsp = 0; newc = 1 - c; end
    else begin w = 0; zsp = 0; end
    if (op != 8'h12) nf[7] = newc[0];
    if (zsp) begin
      nf[6] = (res == 8'h00);
      nf[5] = res[7];
      nf[4] = (ones(res) % 2 == 1);
    end
    return {w, res, nf};
  endfunction

  task automatic chk(input logic [7:0] act, exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] op, a, b, input string tag);
    logic [16:0] e = mdl(op, a, b, mf);
    @(negedge clk);
    op_code = op; acc_in = a; operand = b; op_valid = 1'b1;
    #1;
    chk({7'b0, acc_wr}, {7'b0, e[16]}, {tag, " acc_wr"});
    if (e[16]) chk(acc_out, e[15:8], {tag, " acc_out"});
    @(negedge clk);
    op_valid = 1'b0;
    chk(flags, e[7:0], {tag, " flags"});
    mf = e[7:0];
  endtask

  task automatic t_r1_reset;
    chk(flags, 8'h00, "R1 reset");
  endtask

  task automatic t_r2_logic;
    step(8'h08, 0, 0, "R8 set");
    step(8'h80, 8'hF0, 8'h3C, "R2 and");
    step(8'h8E, 8'h81, 8'h02, "R2 or");
    step(8'h97, 8'h5A, 8'h5A, "R2 xor zero");
    step(8'h86, 8'h7F, 8'h01, "R2 and parity odd");
  endtask

  task automatic t_r3_add;
    step(8'h08, 0, 0, "R8 set");
    step(8'hA0, 8'h10, 8'h20, "R3 add ignores cy");
    step(8'hA6, 8'hFF, 8'h01, "R3 add wrap");
    step(8'hA8, 8'h10, 8'h20, "R3 addc cy=1");
    step(8'hAE, 8'h80, 8'h80, "R3 addc overflow");
    @(negedge clk);
    chk(flags, 8'hC0, "R3 literal cy+zero");
  endtask

  task automatic t_r4_sub;
    step(8'h09, 0, 0, "R8 clr");
    step(8'hB0, 8'h00, 8'h01, "R4 sub borrow");
    chk(flags, 8'hA0, "R4 literal borrow/sign/parity even");
    step(8'hB8, 8'h05, 8'h03, "R4 subb cy=1");
    step(8'hBE, 8'h40, 8'h20, "R4 subb cy=0");
    step(8'hB3, 8'h33, 8'h33, "R4 sub zero");
  endtask

  task automatic t_r5_rot;
    step(8'h09, 0, 0, "R8 clr");
    step(8'h98, 8'h81, 0, "R5 rl");
    step(8'h99, 8'h81, 0, "R5 rlc");
    step(8'h9B, 8'h02, 0, "R5 rrc");
    step(8'h9A, 8'h01, 0, "R5 rr");
    step(8'h9B, 8'h01, 0, "R5 rrc out");
  endtask

  task automatic t_r6_incdec;
    step(8'h08, 0, 0, "R8 set");
    step(8'h9E, 8'hFF, 0, "R6 inc wrap");
    step(8'h9F, 8'h00, 0, "R6 dec wrap");
    step(8'h0F, 8'hA5, 0, "R6 cpl");
    step(8'h9E, 8'h06, 0, "R7 inc parity");
  endtask

  task automatic t_r8_carry;
    step(8'h0E, 0, 0, "R8 cpl");
    step(8'h0E, 0, 0, "R8 cpl back");
    step(8'h09, 0, 0, "R8 clr");
    step(8'h08, 0, 0, "R8 set");
  endtask

  task automatic t_r9_xfer;
    step(8'h12, 8'hDB, 0, "R9 a to flags");
    chk(flags, 8'hD0, "R9 literal load");
    step(8'h11, 8'h00, 0, "R9 flags to a");
    step(8'h12, 8'h2F, 0, "R9 reload");
  endtask

  task automatic t_r10_da;
    step(8'h09, 0, 0, "R8 clr");
    step(8'hFA, 8'h42, 0, "R10 no fix");
    step(8'hFA, 8'h3C, 0, "R10 low fix");
    step(8'hFA, 8'h9A, 0, "R10 both fix");
    chk(flags, 8'hC0, "R10 literal 9A");
    step(8'hFA, 8'h12, 0, "R10 cy forces high");
    step(8'hFA, 8'hFB, 0, "R10 overflow low step");
  endtask

  task automatic t_r11_idle;
    step(8'h08, 0, 0, "R8 set");
    step(8'h00, 8'h55, 8'h55, "R11 reserved");
    step(8'hFB, 8'h00, 8'h00, "R11 reserved2");
    @(negedge clk);
    op_code = 8'h09; acc_in = 8'h00; op_valid = 1'b0;
    #1;
    chk({7'b0, acc_wr}, 8'h00, "R11 idle wr");
    @(negedge clk);
    chk(flags, mf, "R11 idle flags hold");
  endtask

  initial begin
    #100000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_r1_reset();
    t_r2_logic();
    t_r3_add();
    t_r4_sub();
    t_r5_rot();
    t_r6_incdec();
    t_r8_carry();
    t_r9_xfer();
    t_r10_da();
    t_r11_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule